// File: doc/BRIEF.md
# Per-Peripheral Reset Controller

This block drives one active-high reset line to each of a set of peripherals (25 by default) and is configured through an APB slave port. Software holds a peripheral in reset by setting its bit in a control register and lets it run by clearing that bit. All peripherals come up held in reset, so software releases them one by one once clocks and pads are ready.

A second register marks which peripherals a watchdog event must knock back into reset. A one-cycle watchdog pulse sets the marked bits of the control register. Those peripherals then stay in reset until software clears the bits again. A third, read-only register reports which peripherals have acknowledged that they are ready. Each peripheral returns a done level, and the block resynchronises it before capture. A done bit never reads 1 while that peripheral's reset is asserted.

Top module: `periph_rst_ctrl`

## Requirements
- R1: `rst_out` equals the control register (offset 0x000, read-write). A 1 in bit n holds peripheral n in reset. An APB write to offset 0x000 updates `rst_out` at the clock edge that completes the access phase.
- R2: While `presetn` is low, the control register becomes 0x01FFFFFF, the watchdog select register becomes 0 and the status register becomes 0.
- R3: The watchdog select register at offset 0x004 is read-write. Its value does not change `rst_out` unless `wdog_fire` is high.
- R4: When `wdog_fire` is high at a clock edge, every control bit whose select bit held 1 before that edge is set to 1 at that edge. If a control write occurs in the same cycle, the selected bits still end at 1. The set bits stay at 1 until software writes them to 0.
- R5: The status register at offset 0x008 is read-only. Bit n reads `done_in[n]` as sampled three clock edges earlier: two synchroniser stages, then the capture stage. The bit is masked as described in R6.
- R6: A status bit is cleared at the same edge at which its reset output rises. It never reads 1 while `rst_out` for that channel is 1.
- R7: Register bits 31:25 always read 0, and writing them has no effect.
- R8: Every transfer completes with zero wait states: `pready` is 1 and `pslverr` is 0. `prdata` is 0 whenever `psel` is low.
- R9: Writes to offset 0x008 or to any unmapped offset change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| wdog_fire | input | 1 | Watchdog event pulse |
| done_in | input | 25 | Per-peripheral done levels, asynchronous |
| rst_out | output | 25 | Per-peripheral active-high resets |

## Verification
A corrupted control bit appears on `rst_out` at the very next edge, so comparing `rst_out` against a model every cycle catches it immediately. A wrong select bit stays hidden until a watchdog pulse, so the bench fires the watchdog with several masks and also fires it together with a control write. Faults in the synchroniser or the capture stage appear only as a status value that arrives at the wrong cycle, or as a status bit that shows 1 while its reset is asserted. The bench therefore holds a read of offset 0x008 open across done transitions and across watchdog events, and checks the status value in every cycle.

// File: rtl/periph_rst_ctrl.sv
module periph_rst_ctrl #(
  parameter int NCH = 25,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          wdog_fire,
  input  logic [NCH-1:0] done_in,
  output logic [NCH-1:0] rst_out
);
  localparam logic [AW-1:0] OFF_HOLD = AW'(0);
  localparam logic [AW-1:0] OFF_WSEL = AW'(4);
  localparam logic [AW-1:0] OFF_DONE = AW'(8);
  localparam int PAD = DW - NCH;

  logic [NCH-1:0] hold_q, sel_q, sync1_q, sync2_q, done_q;
  logic [NCH-1:0] hold_d, sel_d, rd_bits;
  logic wr_en;

  assign wr_en = psel & penable & pwrite;

  always_comb begin
    hold_d = hold_q;
    sel_d  = sel_q;
    if (wr_en && paddr == OFF_HOLD) hold_d = pwdata[NCH-1:0];
    if (wr_en && paddr == OFF_WSEL) sel_d  = pwdata[NCH-1:0];
    if (wdog_fire) hold_d = hold_d | sel_q;
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      hold_q  <= '1;
      sel_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      done_q  <= '0;
    end else begin
      hold_q  <= hold_d;
      sel_q   <= sel_d;
      sync1_q <= done_in;
      sync2_q <= sync1_q;
      done_q  <= sync2_q & ~hold_d;
    end
  end

  always_comb begin
    case (paddr)
      OFF_HOLD: rd_bits = hold_q;
      OFF_WSEL: rd_bits = sel_q;
      OFF_DONE: rd_bits = done_q;
      default:  rd_bits = '0;
    endcase
  end

  assign prdata  = psel ? {{PAD{1'b0}}, rd_bits} : '0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign rst_out = hold_q;

  AST_HOLD_STABLE: assert property (@(posedge pclk) disable iff (!presetn)
    !(wr_en && paddr == OFF_HOLD) && !wdog_fire |=> $stable(rst_out)); // R1
  AST_SEL_STABLE: assert property (@(posedge pclk) disable iff (!presetn)
    !(wr_en && paddr == OFF_WSEL) |=> $stable(sel_q)); // R3
  AST_WDOG_SETS: assert property (@(posedge pclk) disable iff (!presetn)
    wdog_fire |=> ((rst_out & $past(sel_q)) == $past(sel_q))); // R4
  AST_DONE_MASKED: assert property (@(posedge pclk) disable iff (!presetn)
    psel && paddr == OFF_DONE |-> (prdata[NCH-1:0] & rst_out) == '0); // R6
  AST_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    prdata[DW-1:NCH] == '0); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    psel && paddr != OFF_HOLD && paddr != OFF_WSEL && paddr != OFF_DONE |-> prdata == '0); // R9
endmodule

// File: tb/sim_periph_rst_ctrl.sv
module sim_periph_rst_ctrl;
  localparam int NCH = 25;
  logic clk = 0, rstn = 0;
  logic psel = 0, penable = 0, pwrite = 0, wdog = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0, rdv;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [NCH-1:0] done_in = 0, rst_out;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  periph_rst_ctrl u0 (.pclk(clk), .presetn(rstn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .wdog_fire(wdog), .done_in(done_in), .rst_out(rst_out));

  // behavioural reference model
  logic [NCH-1:0] m_hold, m_sel, m_q1, m_q2, m_done, nh, ns;
  always @(posedge clk) begin
    if (!rstn) begin
      m_hold = '1; m_sel = '0; m_q1 = '0; m_q2 = '0; m_done = '0;
    end else begin
      nh = m_hold; ns = m_sel;
      if (psel && penable && pwrite && paddr == 12'h000) nh = pwdata[NCH-1:0];
      if (psel && penable && pwrite && paddr == 12'h004) ns = pwdata[NCH-1:0];
      if (wdog) nh = nh | m_sel;
      m_done = m_q2 & ~nh;
      m_q2 = m_q1; m_q1 = done_in;
      m_hold = nh; m_sel = ns;
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return {7'b0, m_hold};
      12'h004: return {7'b0, m_sel};
      12'h008: return {7'b0, m_done};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after each edge
  always @(posedge clk) begin
    #2;
    if (rstn) begin
      check(rst_out == m_hold, "R1 rst_out", {7'b0, rst_out}, {7'b0, m_hold});
      check(pready && !pslverr, "R8 ready/err", {30'b0, pready, pslverr}, 32'h2);
      if (psel)
        check(prdata == m_read(paddr),
          paddr == 12'h000 ? "R1 read" : paddr == 12'h004 ? "R3 read" :
          paddr == 12'h008 ? "R5 read" : "R9 read", prdata, m_read(paddr));
      else
        check(prdata == 0, "R8 idle prdata", prdata, 0);
      check((m_done & m_hold) == 0 && ((prdata[NCH-1:0] & rst_out) == 0 || paddr != 12'h008 || !psel),
        "R6 masked", prdata, {7'b0, m_done});
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(posedge clk); #2 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic fire;
    @(negedge clk); wdog = 1;
    @(negedge clk); wdog = 0;
  endtask

  initial begin
    fork
      begin #1_000_000; n_chk++; n_bad++; $display("FAIL watchdog timeout"); end
      begin
        repeat (3) @(negedge clk);
        rstn = 1;
        @(posedge clk); #2;
        check(rst_out == 25'h1FFFFFF, "R2 reset rst_out", {7'b0, rst_out}, 32'h01FFFFFF);
        apb_rd(12'h004, rdv); check(rdv == 0, "R2 wsel reset", rdv, 0);
        apb_rd(12'h008, rdv); check(rdv == 0, "R2 done reset", rdv, 0);
        // R1 release some channels
        apb_wr(12'h000, 32'h01F0_0F0F);
        check(rst_out == 25'h1F00F0F, "R1 write", {7'b0, rst_out}, 32'h01F00F0F);
        apb_wr(12'h000, 32'h0);
        check(rst_out == 0, "R1 all released", {7'b0, rst_out}, 0);
        // R5 latency: hold status read open while done rises
        @(negedge clk); psel = 1; paddr = 12'h008;
        done_in = 25'h0000ABC;
        repeat (2) @(negedge clk);
        check(prdata == 0, "R5 not before 3 edges", prdata, 0);
        @(negedge clk);
        check(prdata == 32'h0000ABC, "R5 after 3 edges", prdata, 32'h0000ABC);
        done_in = '1;
        repeat (4) @(negedge clk);
        check(prdata == 32'h01FFFFFF, "R5 all done", prdata, 32'h01FFFFFF);
        psel = 0;
        // R3 select register
        apb_wr(12'h004, 32'h0000_0030);
        apb_rd(12'h004, rdv); check(rdv == 32'h30, "R3 wsel readback", rdv, 32'h30);
        check(rst_out == 0, "R3 no effect without fire", {7'b0, rst_out}, 0);
        // R4/R6 watchdog fire with status read open
        @(negedge clk); psel = 1; paddr = 12'h008;
        wdog = 1;
        @(posedge clk); #2;
        check(rst_out == 25'h30, "R4 fire sets selected", {7'b0, rst_out}, 32'h30);
        check((prdata[NCH-1:0] & 25'h30) == 0, "R6 cleared same edge", prdata, {7'b0, m_done});
        @(negedge clk); wdog = 0; psel = 0;
        repeat (5) @(negedge clk);
        check(rst_out == 25'h30, "R4 stays held", {7'b0, rst_out}, 32'h30);
        // R4 simultaneous write and fire: fired bits win
        apb_wr(12'h004, 32'h0000_0101);
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h000; pwdata = 32'h0000_1000;
        @(negedge clk); penable = 1; wdog = 1;
        @(posedge clk); #2;
        check(rst_out == 25'h1101, "R4 fire beats write", {7'b0, rst_out}, 32'h1101);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; wdog = 0;
        // R7 upper bits
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_rd(12'h000, rdv); check(rdv == 32'h01FFFFFF, "R7 upper bits zero", rdv, 32'h01FFFFFF);
        apb_wr(12'h000, 32'hFE00_0000);
        check(rst_out == 0, "R7 upper write ignored", {7'b0, rst_out}, 0);
        // R9 read-only and unmapped
        apb_wr(12'h008, 32'h0);
        apb_wr(12'h010, 32'hFFFF_FFFF);
        apb_wr(12'h00C, 32'hFFFF_FFFF);
        apb_rd(12'h004, rdv); check(rdv == 32'h101, "R9 unmapped write ignored", rdv, 32'h101);
        apb_rd(12'h008, rdv); check(rdv == 32'h01FFFFFF, "R9 status unchanged", rdv, 32'h01FFFFFF);
        apb_rd(12'h010, rdv); check(rdv == 0, "R9 unmapped read", rdv, 0);
        // done falls while released
        done_in = 25'h0F0F0F0;
        repeat (4) @(negedge clk);
        apb_rd(12'h008, rdv); check(rdv == 32'h00F0F0F0, "R5 done falls", rdv, 32'h00F0F0F0);
        // R2 reset mid-run
        @(negedge clk); rstn = 0;
        @(negedge clk); rstn = 1;
        check(rst_out == 25'h1FFFFFF, "R2 re-reset", {7'b0, rst_out}, 32'h01FFFFFF);
        apb_rd(12'h004, rdv); check(rdv == 0, "R2 wsel re-reset", rdv, 0);
        repeat (3) @(negedge clk);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule